// File: doc/BRIEF.md
# Paired Set/Clear Level Interrupt Controller

This block gathers up to 32 level-sensitive peripheral interrupt lines and presents them to a processor as two request lines and one wake line. Each source has its own state bits: a three-bit trigger code, an enable bit, a wake-enable bit, a routing bit and a source-select bit. Every one of these state words has its own read address, set address and clear address. Software therefore changes single bits without a read-modify-write sequence. A 1 in the write data acts on the bit in that position, and a 0 leaves the bit alone.

Each input first passes through a two-flop synchronizer. The trigger code then decides whether the source is active on a high level, active on a low level, or never active. An active source whose enable bit is set is pending. Its routing bit steers it to one of two read-only status words, and each request line is the OR of its status word. Because detection follows the level, a source stops being pending as soon as its input drops. No acknowledge write is needed. The wake line follows active sources that have wake-enable set, whatever their enable bit holds.

The bus is a plain synchronous register port with an address, write data, a write strobe and combinational read data. It accepts one write per cycle, and the most recent write to a bit decides its value. There is no streaming data path, so no valid/ready handshake applies.

Top module: `sc_icu`

## Requirements
- R1: After reset, every readable word returns 0, and `req0_irq`, `req1_irq` and `wake_req` are low.
- R2: The address is {bank[4:2], op[1:0]}. Banks 0 to 6 hold, in order, trigger code bit 0, trigger code bit 1, trigger code bit 2, enable, wake-enable, routing and source-select. A write to op 1 (set) of one of these banks sets every bit that is 1 in the write data and leaves the other bits unchanged.
- R3: A write to op 2 (clear) of banks 0 to 6 clears every bit that is 1 in the write data and leaves the other bits unchanged. A later write overrides an earlier one on the same bit.
- R4: Source n can become active only through its trigger code {bit2,bit1,bit0}. Code 101 makes it active while its synchronized input is 1. Code 110 makes it active while the input is 0. Any other code, including 000 and 111, never makes it active.
- R5: A change on `irq_in` that is set up before rising edge k first shows in the status words and request lines after edge k+1. After edge k alone it is not yet visible.
- R6: A pending source whose routing bit is 1 appears only in status word 0 (bank 7, op 0). A pending source whose routing bit is 0 appears only in status word 1 (bank 7, op 1).
- R7: A source whose enable bit is 0 appears in neither status word.
- R8: `req0_irq` is high exactly when status word 0 is non-zero, and `req1_irq` is high exactly when status word 1 is non-zero.
- R9: `wake_req` is high exactly when some source is active and has its wake-enable bit set, regardless of its enable bit.
- R10: Bank 7, op 2 is a plain read/write test word that resets to 0. Writes to op 0 of any bank, to op 3 of any bank, and to the two status words change nothing. Reads of op 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register address {bank, op} |
| bus_wdata | input | N_SRC | Write data, one bit per source |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | N_SRC | Combinational read data for bus_addr |
| irq_in | input | N_SRC | Asynchronous level inputs from the sources |
| req0_irq | output | 1 | Request line 0: OR of status word 0 |
| req1_irq | output | 1 | Request line 1: OR of status word 1 |
| wake_req | output | 1 | Wake line: any active source with wake-enable set |

## Verification
The detection path is swept across all eight trigger codes. Each code is combined with two complementary input patterns and a split routing word. This separates the active-high code from the active-low code and from the six codes that must stay silent. It also shows that each source reaches exactly one status word. A partial enable word and a wake word set on sources that are not enabled tell the enable gate apart from the wake path. A single-bit step on one input marks the two-edge latency. The set and clear addresses of every bank are driven with overlapping patterns, and those results are read back. Stray writes to read, reserved and status addresses are also read back, to show they alter nothing.

// File: rtl/sc_icu_pkg.sv
package sc_icu_pkg;
  localparam int ADDR_W       = 5;
  localparam int NUM_SC_BANKS = 7;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_RSVD = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    BK_CODE0  = 3'd0,
    BK_CODE1  = 3'd1,
    BK_CODE2  = 3'd2,
    BK_ENABLE = 3'd3,
    BK_WAKE   = 3'd4,
    BK_ROUTE  = 3'd5,
    BK_SRCSEL = 3'd6,
    BK_MISC   = 3'd7
  } bank_e;

  localparam logic [2:0] CODE_LVL_HIGH = 3'b101;
  localparam logic [2:0] CODE_LVL_LOW  = 3'b110;
endpackage

// File: rtl/sc_icu_setclr_reg.sv
module sc_icu_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       q <= '0;
    else if (set_stb) q <= q | wdata;
    else if (clr_stb) q <= q & ~wdata;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_stb && clr_stb)); // R2
  AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |=> ((q & $past(q)) == $past(q)) && ((q & $past(wdata)) == $past(wdata))); // R2
  AST_CLR_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |=> ((q & ~$past(q)) == '0) && ((q & $past(wdata)) == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_stb && !clr_stb) |=> $stable(q)); // R10
endmodule

// File: rtl/sc_icu_detect.sv
module sc_icu_detect
  import sc_icu_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_in,
  input  logic [N_SRC-1:0] code0,
  input  logic [N_SRC-1:0] code1,
  input  logic [N_SRC-1:0] code2,
  output logic [N_SRC-1:0] active
);
  logic [N_SRC-1:0] meta_q;
  logic [N_SRC-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      lvl_q  <= '0;
    end else begin
      meta_q <= irq_in;
      lvl_q  <= meta_q;
    end
  end

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    logic [2:0] code;
    assign code      = {code2[n], code1[n], code0[n]};
    assign active[n] = ((code == CODE_LVL_HIGH) &&  lvl_q[n]) ||
                       ((code == CODE_LVL_LOW)  && !lvl_q[n]);
  end

  AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (active & ~(code2 & (code1 ^ code0))) == '0); // R4
endmodule

// File: rtl/sc_icu_route.sv
module sc_icu_route #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] active,
  input  logic [N_SRC-1:0] enable,
  input  logic [N_SRC-1:0] route,
  input  logic [N_SRC-1:0] wake_en,
  output logic [N_SRC-1:0] stat0,
  output logic [N_SRC-1:0] stat1,
  output logic             req0,
  output logic             req1,
  output logic             wake
);
  logic [N_SRC-1:0] pending;

  assign pending = active & enable;
  assign stat0   = pending & route;
  assign stat1   = pending & ~route;
  assign req0    = |stat0;
  assign req1    = |stat1;
  assign wake    = |(active & wake_en);

  AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (stat0 & stat1) == '0); // R6
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat0 | stat1) & ~enable) == '0); // R7
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req0 || req1) |-> (enable != '0)); // R8
  AST_WAKE_NEEDS_WAKE_EN: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (wake_en != '0)); // R9
endmodule

// File: rtl/sc_icu.sv
module sc_icu
  import sc_icu_pkg::*;
#(
  parameter int N_SRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  irq_in,
  output logic              req0_irq,
  output logic              req1_irq,
  output logic              wake_req
);
  logic [2:0]       bank;
  logic [1:0]       op;
  logic [N_SRC-1:0] bank_q [NUM_SC_BANKS];
  logic [N_SRC-1:0] test_q;
  logic [N_SRC-1:0] active, stat0, stat1;

  assign bank = bus_addr[4:2];
  assign op   = bus_addr[1:0];

  for (genvar b = 0; b < NUM_SC_BANKS; b++) begin : g_bank
    localparam logic [2:0] BIDX = 3'(b);
    logic set_stb, clr_stb;
    assign set_stb = bus_we && (bank == BIDX) && (op == OP_SET);
    assign clr_stb = bus_we && (bank == BIDX) && (op == OP_CLR);
    sc_icu_setclr_reg #(.W(N_SRC)) u_reg (
      .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
      .wdata(bus_wdata), .q(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) test_q <= '0;
    else if (bus_we && bank == BK_MISC && op == OP_CLR) test_q <= bus_wdata;
  end

  sc_icu_detect #(.N_SRC(N_SRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .code0(bank_q[BK_CODE0]), .code1(bank_q[BK_CODE1]), .code2(bank_q[BK_CODE2]),
    .active(active)
  );

  sc_icu_route #(.N_SRC(N_SRC)) u_route (
    .clk(clk), .rst_n(rst_n), .active(active),
    .enable(bank_q[BK_ENABLE]), .route(bank_q[BK_ROUTE]), .wake_en(bank_q[BK_WAKE]),
    .stat0(stat0), .stat1(stat1),
    .req0(req0_irq), .req1(req1_irq), .wake(wake_req)
  );

  always_comb begin
    bus_rdata = '0;
    if (bank == BK_MISC) begin
      case (op)
        OP_READ: bus_rdata = stat0;
        OP_SET:  bus_rdata = stat1;
        OP_CLR:  bus_rdata = test_q;
        default: bus_rdata = '0;
      endcase
    end else if (op == OP_READ) begin
      for (int b = 0; b < NUM_SC_BANKS; b++)
        if (bank == 3'(b)) bus_rdata = bank_q[b];
    end
  end

  AST_TEST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bank == BK_MISC && op == OP_CLR) |=> $stable(test_q)); // R10
  AST_RESERVED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RSVD) |-> (bus_rdata == '0)); // R10
endmodule

// File: tb/sc_icu_test.sv
module sc_icu_test;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    bus_addr = '0;
  logic [N-1:0]  bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic [N-1:0]  bus_rdata;
  logic [N-1:0]  irq_in = '0;
  logic          req0_irq, req1_irq, wake_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sc_icu #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .req0_irq(req0_irq), .req1_irq(req1_irq), .wake_req(wake_req)
  );

  function automatic logic [4:0] ad(input int bank, input int op);
    return {3'(bank), 2'(op)};
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int bank, input int op, input logic [N-1:0] d);
    @(negedge clk);
    bus_addr = ad(bank, op); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int bank, input int op, output logic [N-1:0] d);
    bus_addr = ad(bank, op);
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v, p, q, r, pat, act, route_w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state of every readable word and the output pins
    for (int b = 0; b < 8; b++) begin
      for (int o = 0; o < 4; o++) begin
        rd(b, o, v); chk("R1 reset read", v, '0);
      end
    end
    chk("R1 reset pins", {29'd0, req0_irq, req1_irq, wake_req}, '0);

    // R2 and R3: set and clear on every set/clear bank
    for (int b = 0; b < 7; b++) begin
      p = 32'h1357_9BDF ^ (32'h1111_1111 * b);
      q = 32'hF000_0F00 >> b;
      r = 32'h0FF0_F0F0 ^ p;
      wr(b, 1, p);  rd(b, 0, v); chk("R2 set from zero", v, p);
      wr(b, 1, q);  rd(b, 0, v); chk("R2 set keeps ones", v, p | q);
      wr(b, 1, '0); rd(b, 0, v); chk("R2 zero set no change", v, p | q);
      wr(b, 2, r);  rd(b, 0, v); chk("R3 clear bits", v, (p | q) & ~r);
      wr(b, 2, '0); rd(b, 0, v); chk("R3 zero clear no change", v, (p | q) & ~r);
      wr(b, 0, '1); rd(b, 0, v); chk("R10 write to read op ignored", v, (p | q) & ~r);
      wr(b, 3, '1); rd(b, 0, v); chk("R10 write to reserved op ignored", v, (p | q) & ~r);
      rd(b, 3, v); chk("R10 reserved op reads zero", v, '0);
      wr(b, 2, '1); rd(b, 0, v); chk("R3 clear all", v, '0);
    end

    // R10: test word and status writes
    wr(7, 2, 32'hDEAD_BEEF); rd(7, 2, v); chk("R10 test word", v, 32'hDEAD_BEEF);
    wr(7, 0, '1); rd(7, 0, v); chk("R10 status0 write ignored", v, '0);
    wr(7, 1, '1); rd(7, 1, v); chk("R10 status1 write ignored", v, '0);
    rd(7, 2, v); chk("R10 test word kept", v, 32'hDEAD_BEEF);
    wr(7, 2, '0);

    // R4, R6, R8: sweep over all eight trigger codes and two input patterns
    route_w = 32'h0000_FFFF;
    wr(3, 1, '1);
    wr(5, 1, route_w);
    for (int c = 0; c < 8; c++) begin
      for (int k = 0; k < 2; k++) begin
        pat = (k == 0) ? 32'hA5A5_3C3C : 32'h5A5A_C3C3;
        wr(0, 2, '1); wr(1, 2, '1); wr(2, 2, '1);
        if (c[0]) wr(0, 1, '1);
        if (c[1]) wr(1, 1, '1);
        if (c[2]) wr(2, 1, '1);
        @(negedge clk); irq_in = pat;
        settle();
        act = (c == 5) ? pat : (c == 6) ? ~pat : '0;
        rd(7, 0, v); chk("R4 R6 status0 by code", v, act & route_w);
        rd(7, 1, v); chk("R4 R6 status1 by code", v, act & ~route_w);
        chk("R8 request pins", {30'd0, req0_irq, req1_irq},
            {30'd0, |(act & route_w), |(act & ~route_w)});
      end
    end

    // R7 and R9: partial enable, wake independent of enable
    wr(0, 2, '1); wr(1, 2, '1); wr(2, 2, '1);
    wr(0, 1, '1); wr(2, 1, '1);
    wr(3, 2, '1); wr(3, 1, 32'h00FF_00FF);
    @(negedge clk); irq_in = '1;
    settle();
    rd(7, 0, v); chk("R7 status0 masked", v, 32'h00FF_00FF & route_w);
    rd(7, 1, v); chk("R7 status1 masked", v, 32'h00FF_00FF & ~route_w);
    chk("R9 wake off with no wake-enable", {31'd0, wake_req}, '0);
    wr(4, 1, 32'hF000_0000);
    #1 chk("R9 wake from a source that is not enabled", {31'd0, wake_req}, 32'd1);
    @(negedge clk); irq_in = 32'h0FFF_FFFF;
    settle();
    chk("R9 wake drops with input", {31'd0, wake_req}, '0);
    wr(3, 2, '1);
    settle();
    chk("R7 all disabled pins", {30'd0, req0_irq, req1_irq}, '0);

    // R5: latency of a single-bit step
    wr(4, 2, '1);
    wr(3, 1, 32'h0000_0001);
    @(negedge clk); irq_in = '0;
    settle();
    rd(7, 0, v); chk("R5 idle before step", v, '0);
    @(negedge clk); irq_in = 32'h0000_0001;
    @(negedge clk);
    rd(7, 0, v); chk("R5 not visible after one edge", v, '0);
    @(negedge clk);
    rd(7, 0, v); chk("R5 visible after two edges", v, 32'h0000_0001);
    chk("R5 R8 request 0 up", {31'd0, req0_irq}, 32'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule